// File: doc/BRIEF.md
# Mask-Compare Chip-Select Decoder

This block sits at the front of a two-rank DRAM controller and works out which rank a bus request belongs to. Each request carries a 32-bit byte address and a valid strobe. The block first checks that the address falls inside the controller's address window. The window bounds are parameters, so that one instance can serve 0x2000_0000..0x3FFF_FFFF and another can serve 0x4000_0000..0x7FFF_FFFF.

Each rank has an 8-bit base and an 8-bit mask. Bits [31:24] of the address are ANDed with a rank's mask, and the result is compared for equality with that rank's base. The mask therefore sets the size of the rank: 0xF8 gives 128 MB, 0xF0 gives 256 MB, 0xE0 gives 512 MB and 0xC0 gives 1 GB.

The winning rank drives its chip-select bit. The rank offset is the address with the masked top bits cleared. Requests that fall outside the window, or that match no rank, raise a one-cycle miss flag instead. All outputs are registered, one cycle after the request.

Top module: `csdec_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cs_sel`, `rank_off` and `miss` are all zero.
- R2: Outputs follow a request one clock later. A cycle with `req_valid` low yields `cs_sel`=0, `miss`=0 and `rank_off`=0 on the next cycle.
- R3: A valid address below `WIN_LO` or above `WIN_HI` (both bounds inclusive) gives `miss`=1 and `cs_sel`=0, whatever the rank settings.
- R4: A valid in-window address with `(addr[31:24] & mask_i) == base_i` asserts `cs_sel[i]`. Bit 0 is rank 0 (`cs0_*`) and bit 1 is rank 1 (`cs1_*`).
- R5: When both ranks match, only `cs_sel[0]` is asserted.
- R6: A valid in-window address that matches neither rank gives `miss`=1 and `cs_sel`=0.
- R7: `rank_off` equals `addr & ~{mask, 24'h0}`, using the mask of the selected rank. It is zero on a miss.
- R8: `cs_sel` has at most one bit set, and `miss` is never high together with any `cs_sel` bit.
- R9: With the contiguous 128 MB layout (rank 0 base 0x20, rank 1 base 0x28, both masks 0xF8), 0x23xx_xxxx selects rank 0 and 0x28xx_xxxx selects rank 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W (32) | Request byte address |
| cs0_base | input | SEL_W (8) | Rank 0 base byte |
| cs0_mask | input | SEL_W (8) | Rank 0 mask byte |
| cs1_base | input | SEL_W (8) | Rank 1 base byte |
| cs1_mask | input | SEL_W (8) | Rank 1 mask byte |
| cs_sel | output | 2 | One-hot chip select, registered |
| rank_off | output | ADDR_W (32) | Offset inside the selected rank |
| miss | output | 1 | One-cycle flag for a request out of window or matching no rank |

## Verification
The bench probes the window edges at 0x1FFF_FFFF, 0x2000_0000, 0x3FFF_FFFF and 0x4000_0000.
- A bound compared with the wrong inequality selects a rank one byte outside the window.
- A bound compared in the other direction drops the first or the last byte of the window.

Overlapping ranks show whether the priority is right: a design that prefers rank 1, or that ORs the two hits, gives the wrong or a two-hot chip select. Ranks are also given different masks, so that an offset computed with the other rank's mask is visible. Addresses inside the window that match no rank, and idle cycles, show whether a design raises a false select or leaves a stale output.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int NUM_RANKS = 2;
  typedef logic [NUM_RANKS-1:0] cs_vec_t;
endpackage

// File: rtl/csdec_window.sv
module csdec_window #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h3FFF_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);
  always_comb begin
    in_win = (addr >= WIN_LO) && (addr <= WIN_HI);
  end
endmodule

// File: rtl/csdec_rank_cmp.sv
module csdec_rank_cmp #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  base,
  input  logic [SEL_W-1:0]  mask,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  localparam int LOW_W = ADDR_W - SEL_W;

  logic [SEL_W-1:0]  top_byte;
  logic [ADDR_W-1:0] keep;

  always_comb begin
    top_byte = addr[ADDR_W-1:LOW_W];
    hit      = ((top_byte & mask) == base);
    keep     = {~mask, {LOW_W{1'b1}}};
    offset   = addr & keep;
  end
endmodule

// File: rtl/csdec_pick.sv
module csdec_pick
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  cs_vec_t                     hits,
  input  logic [NUM_RANKS*ADDR_W-1:0] offs,
  output cs_vec_t                     sel,
  output logic [ADDR_W-1:0]           off,
  output logic                        any
);
  always_comb begin
    sel = '0;
    off = '0;
    // Walk from the highest rank down so that the lowest matching rank wins.
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
        off    = offs[i*ADDR_W +: ADDR_W];
      end
    end
    any = |hits;
  end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h3FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SEL_W-1:0]  cs0_base,
  input  logic [SEL_W-1:0]  cs0_mask,
  input  logic [SEL_W-1:0]  cs1_base,
  input  logic [SEL_W-1:0]  cs1_mask,
  output logic [1:0]        cs_sel,
  output logic [ADDR_W-1:0] rank_off,
  output logic              miss
);
  logic [NUM_RANKS*SEL_W-1:0]  base_all;
  logic [NUM_RANKS*SEL_W-1:0]  mask_all;
  logic [NUM_RANKS*ADDR_W-1:0] off_all;
  cs_vec_t                     hit_vec;
  cs_vec_t                     pick_sel;
  logic [ADDR_W-1:0]           pick_off;
  logic                        pick_any;
  logic                        in_win;

  assign base_all = {cs1_base, cs0_base};
  assign mask_all = {cs1_mask, cs0_mask};

  csdec_window #(
    .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_window (
    .addr(req_addr), .in_win(in_win)
  );

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
    csdec_rank_cmp #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W)
    ) u_cmp (
      .addr  (req_addr),
      .base  (base_all[g*SEL_W +: SEL_W]),
      .mask  (mask_all[g*SEL_W +: SEL_W]),
      .hit   (hit_vec[g]),
      .offset(off_all[g*ADDR_W +: ADDR_W])
    );
  end

  csdec_pick #(.ADDR_W(ADDR_W)) u_pick (
    .hits(hit_vec), .offs(off_all), .sel(pick_sel), .off(pick_off), .any(pick_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sel   <= '0;
      rank_off <= '0;
      miss     <= 1'b0;
    end else if (req_valid && in_win && pick_any) begin
      cs_sel   <= pick_sel;
      rank_off <= pick_off;
      miss     <= 1'b0;
    end else begin
      cs_sel   <= '0;
      rank_off <= '0;
      miss     <= req_valid;
    end
  end
endmodule

// File: rtl/csdec_checker.sv
module csdec_checker #(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 8,
  parameter logic [ADDR_W-1:0] WIN_LO = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 32'h3FFF_FFFF
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SEL_W-1:0]  cs0_mask,
  input logic [SEL_W-1:0]  cs1_mask,
  input logic [1:0]        cs_sel,
  input logic [ADDR_W-1:0] rank_off,
  input logic              miss
);
  localparam int LOW_W = ADDR_W - SEL_W;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (cs_sel == 2'b00 && !miss)) else $error("reset"); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (cs_sel == 2'b00 && !miss && rank_off == '0)) else $error("idle"); // R2
  AST_OUT_OF_WIN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_addr < WIN_LO || req_addr > WIN_HI)) |=> (miss && cs_sel == 2'b00)) else $error("window"); // R3
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst) $onehot0(cs_sel)) else $error("onehot"); // R8
  AST_MISS_EXCL: assert property (@(posedge clk) disable iff (rst) !(miss && cs_sel != 2'b00)) else $error("excl"); // R8
  AST_OFF0_MASKED: assert property (@(posedge clk) disable iff (rst)
    cs_sel[0] |-> ((rank_off[ADDR_W-1:LOW_W] & $past(cs0_mask)) == '0)) else $error("off0"); // R7
  AST_OFF1_MASKED: assert property (@(posedge clk) disable iff (rst)
    cs_sel[1] |-> ((rank_off[ADDR_W-1:LOW_W] & $past(cs1_mask)) == '0)) else $error("off1"); // R7
endmodule

bind csdec_top csdec_checker #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_csdec_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .cs0_mask(cs0_mask), .cs1_mask(cs1_mask),
  .cs_sel(cs_sel), .rank_off(rank_off), .miss(miss)
);

// File: tb/test_csdec_top.sv
module test_csdec_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  cs0_base = '0, cs0_mask = '0, cs1_base = '0, cs1_mask = '0;
  logic [1:0]  cs_sel;
  logic [31:0] rank_off;
  logic        miss;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  csdec_top i_csdec_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .cs0_base(cs0_base), .cs0_mask(cs0_mask), .cs1_base(cs1_base), .cs1_mask(cs1_mask),
    .cs_sel(cs_sel), .rank_off(rank_off), .miss(miss)
  );

  task automatic chk(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: expected outputs for one request.
  task automatic model(input bit v, input longint a, output int e_cs, output longint e_off, output int e_miss);
    longint top;
    bit h0, h1;
    e_cs = 0; e_off = 0; e_miss = 0;
    if (!v) return;
    if (a < 64'h2000_0000 || a > 64'h3FFF_FFFF) begin e_miss = 1; return; end
    top = a / (64'd1 << 24);
    h0 = ((top & cs0_mask) == cs0_base);
    h1 = ((top & cs1_mask) == cs1_base);
    if (h0) begin e_cs = 1; e_off = a % ((256 - cs0_mask) * (64'd1 << 24)); end
    else if (h1) begin e_cs = 2; e_off = a % ((256 - cs1_mask) * (64'd1 << 24)); end
    else e_miss = 1;
  endtask

  // Drive at a falling edge, check at the next falling edge.
  task automatic step(string tag, bit v, logic [31:0] a);
    int e_cs, e_miss;
    longint e_off;
    @(negedge clk);
    req_valid = v;
    req_addr  = a;
    model(v, {32'h0, a}, e_cs, e_off, e_miss);
    @(negedge clk);
    chk(tag, "cs_sel", cs_sel, e_cs);
    chk(tag, "miss", miss, e_miss);
    chk(tag, "rank_off", rank_off, e_off);
  endtask

  // Used only for non-power-of-two-style masks in the sweep: bitwise model.
  task automatic step_bits(string tag, logic [31:0] a);
    int e_cs, e_miss;
    logic [31:0] e_off;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    e_cs = 0; e_miss = 0; e_off = '0;
    if (a < 32'h2000_0000 || a > 32'h3FFF_FFFF) e_miss = 1;
    else if ((a[31:24] & cs0_mask) == cs0_base) begin e_cs = 1; e_off = a & ~({cs0_mask, 24'h0}); end
    else if ((a[31:24] & cs1_mask) == cs1_base) begin e_cs = 2; e_off = a & ~({cs1_mask, 24'h0}); end
    else e_miss = 1;
    @(negedge clk);
    chk(tag, "cs_sel", cs_sel, e_cs);
    chk(tag, "miss", miss, e_miss);
    chk(tag, "rank_off", rank_off, e_off);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req_valid = 1'b1;
    req_addr  = 32'h2300_0000;
    cs0_base = 8'h20; cs0_mask = 8'hF8; cs1_base = 8'h28; cs1_mask = 8'hF8;
    repeat (3) @(negedge clk);
    chk("R1", "cs_sel", cs_sel, 0);
    chk("R1", "miss", miss, 0);
    chk("R1", "rank_off", rank_off, 0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "cs_sel_after", cs_sel, 0);

    // R9 contiguous 128 MB layout
    step("R9", 1'b1, 32'h2345_6789);
    step("R9", 1'b1, 32'h2812_3456);
    step("R4", 1'b1, 32'h2FFF_FFFF);
    step("R2", 1'b0, 32'h2345_6789);
    step("R6", 1'b1, 32'h3000_0010);
    step("R2", 1'b1, 32'h2000_0004);
    step("R2", 1'b0, 32'h2800_0000);
    // R3 window edges
    step("R3", 1'b1, 32'h1FFF_FFFF);
    step("R3", 1'b1, 32'h2000_0000);
    step("R3", 1'b1, 32'h4000_0000);
    step("R3", 1'b1, 32'hFFFF_FFFF);
    cs1_base = 8'h38;
    step("R3", 1'b1, 32'h3FFF_FFFF);
    // R3: a permissive rank must not catch out-of-window addresses
    cs0_base = 8'h00; cs0_mask = 8'h00;
    step("R3", 1'b1, 32'h4800_0000);
    step("R3", 1'b1, 32'h0000_1000);
    // R5 overlap: both ranks match
    cs0_base = 8'h20; cs0_mask = 8'hE0; cs1_base = 8'h20; cs1_mask = 8'hF0;
    step("R5", 1'b1, 32'h2123_4567);
    step("R5", 1'b1, 32'h3ABC_DEF0);
    // R7 different masks per rank
    cs0_base = 8'h20; cs0_mask = 8'hF0; cs1_base = 8'h30; cs1_mask = 8'hF8;
    step("R7", 1'b1, 32'h2F00_00AA);
    step("R7", 1'b1, 32'h37FF_FFFF);
    step("R6", 1'b1, 32'h3800_0000);
    // R4 512 MB on one rank
    cs0_base = 8'h20; cs0_mask = 8'hE0; cs1_base = 8'hFF; cs1_mask = 8'hFF;
    step("R4", 1'b1, 32'h3F12_3456);
    // R8 and general: pseudo-random sweep with arbitrary masks
    for (int n = 0; n < 300; n++) begin
      cs0_mask = 8'($urandom);
      cs1_mask = 8'($urandom);
      cs0_base = 8'($urandom) & cs0_mask;
      cs1_base = 8'($urandom) & cs1_mask;
      if (n % 5 == 0) req_valid = 1'b0;
      if (n % 5 == 0) step("R2", 1'b0, $urandom);
      else step_bits("R8", 32'h1800_0000 + ($urandom % 32'h3000_0000));
    end
    @(negedge clk);
    req_valid = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule